// File: doc/BRIEF.md
# Serial Identity-Code CRC-8 Unit

This block computes an 8-bit cyclic redundancy check one bit at a time over a 64-bit device identity code. The code places an 8-bit family code in its lowest byte, a 48-bit serial number above it, and the 8-bit check byte in its top byte. The generator polynomial is x^8 + x^5 + x^4 + 1. The register is held in reflected form and is fed least significant bit first.

A wrapper issues a clear and then presents one bit per strobe. To build a check byte, it streams the 56 family and serial bits and reads the remainder. To verify a received code, it streams all 64 bits and reads the valid flag. The flag is set only when exactly 64 bits have entered since the last clear and the residue is zero.

Top module: `idcrc8_serial`

## Requirements
- R1: After reset the remainder output is 0x00 and the valid flag is 0.
- R2: A high clear sets the remainder to 0x00 and the bit count to zero on the next clock edge. It does so even when a bit strobe is high in the same cycle; that bit is dropped.
- R3: On a strobe without clear, let fb = data bit XOR remainder bit 0. The new remainder is the old one shifted right by one with a 0 entering bit 7, then XORed with 0x8C when fb is 1 (bits 7, 3 and 2).
- R4: In a cycle with neither clear nor strobe, the remainder and the valid flag hold their values.
- R5: After a clear and 56 bits taken LSB first from code bits 0..55, the remainder equals the check byte. For family 0x02 and serial 0x000001B81C the remainder is 0xA2.
- R6: After a clear and the 64 bits of a well-formed code (check byte in bits 63..56), the remainder is 0x00 and the valid flag is 1.
- R7: The valid flag is 1 only when exactly 64 strobes have been taken since the last clear. At 63 bits, or at 65 or more bits, the flag is 0 even if the remainder is zero. It stays 0 until the next clear.
- R8: A 64-bit code with any single bit inverted leaves the valid flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of remainder and bit count |
| bit_vld_i | input | 1 | Strobe: take `bit_i` this cycle |
| bit_i | input | 1 | Serial data bit, LSB of the code first |
| rem_o | output | 8 | Current CRC remainder |
| code_ok_o | output | 1 | Exactly 64 bits taken and remainder zero |

## Verification
On every cycle, the assertions check the following:
- the single-bit step of the register (the feedback bit enters bit 7 and the upper bits shift down);
- that clear wins over a same-cycle strobe;
- that idle cycles hold state;
- that the flag never rises with a nonzero remainder or at a bit count other than 64.

Only the bench scenarios can show that the 56-bit remainder matches a known check byte, that a full well-formed code leaves a zero residue, and that a single inverted bit is caught. The bench also shows that the flag falls again on the 65th bit.

// File: rtl/idcrc8_pkg.sv
package idcrc8_pkg;
  // CRC register width and the reflected tap mask of x^8+x^5+x^4+1
  localparam int unsigned CRC_W     = 8;
  localparam logic [7:0]  POLY_REFL = 8'h8C;
  // total length of one identity code in bits
  localparam int unsigned CODE_BITS = 64;
endpackage

// File: rtl/idcrc8_rst_sync.sv
module idcrc8_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/idcrc8_lfsr.sv
module idcrc8_lfsr #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] shift_nxt;
  logic [W-1:0] crc_d;
  logic         fb;
  logic         en;

  assign fb = din ^ crc_q[0];

  // one stage per bit: shift right, inject feedback where the mask has a tap
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W-1) begin : g_top
      assign shift_nxt[i] = POLY[i] & fb;
    end else begin : g_mid
      assign shift_nxt[i] = crc_q[i+1] ^ (POLY[i] & fb);
    end
  end

  always_comb begin
    en    = clr | step;
    crc_d = crc_q;
    if (clr)       crc_d = '0;
    else if (step) crc_d = shift_nxt;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)  crc_q <= '0;
    else if (en)  crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/idcrc8_bitcnt.sv
module idcrc8_bitcnt #(
  parameter int unsigned LEN = 64,
  localparam int unsigned CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic clr,
  input  logic step,
  output logic at_len
);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          over_q, over_d;
  logic          en;

  always_comb begin
    en     = clr | step;
    cnt_d  = cnt_q;
    over_d = over_q;
    if (clr) begin
      cnt_d  = '0;
      over_d = 1'b0;
    end else if (step) begin
      if (cnt_q == FULL) over_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      over_q <= over_d;
    end
  end

  assign at_len = (cnt_q == FULL) & ~over_q;
endmodule

// File: rtl/idcrc8_serial.sv
module idcrc8_serial
  import idcrc8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] rem_o,
  output logic             code_ok_o
);
  logic rst_ns;
  logic at_len;
  logic [CRC_W-1:0] crc;

  idcrc8_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  idcrc8_lfsr #(.W(CRC_W), .POLY(POLY_REFL)) u_lfsr (
    .clk(clk), .rst_ns(rst_ns), .clr(clr_i), .step(bit_vld_i),
    .din(bit_i), .crc(crc)
  );

  idcrc8_bitcnt #(.LEN(CODE_BITS)) u_cnt (
    .clk(clk), .rst_ns(rst_ns), .clr(clr_i), .step(bit_vld_i),
    .at_len(at_len)
  );

  assign rem_o     = crc;
  assign code_ok_o = at_len & (crc == '0);
endmodule

// File: rtl/idcrc8_serial_chk.sv
module idcrc8_serial_chk
  import idcrc8_pkg::*;
(
  input logic             clk,
  input logic             rst_ns,
  input logic             clr_i,
  input logic             bit_vld_i,
  input logic             bit_i,
  input logic [CRC_W-1:0] rem_o,
  input logic             code_ok_o
);
  // independent count of strobes since clear, saturating
  logic [7:0] ck_cnt;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                         ck_cnt <= '0;
    else if (clr_i)                      ck_cnt <= '0;
    else if (bit_vld_i && ck_cnt != 8'hFF) ck_cnt <= ck_cnt + 8'd1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_ns)
    clr_i |=> (rem_o == '0 && !code_ok_o)); // R2

  AST_STEP_TOP: assert property (@(posedge clk) disable iff (!rst_ns)
    (bit_vld_i && !clr_i) |=> rem_o[CRC_W-1] == ($past(bit_i) ^ $past(rem_o[0]))); // R3

  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_ns)
    (bit_vld_i && !clr_i) |=> rem_o[6] == $past(rem_o[7])); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!bit_vld_i && !clr_i) |=> ($stable(rem_o) && $stable(code_ok_o))); // R4

  AST_OK_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    code_ok_o |-> rem_o == '0); // R6

  AST_OK_LEN: assert property (@(posedge clk) disable iff (!rst_ns)
    code_ok_o |-> ck_cnt == 8'(CODE_BITS)); // R7
endmodule

bind idcrc8_serial idcrc8_serial_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
  .bit_i(bit_i), .rem_o(rem_o), .code_ok_o(code_ok_o)
);

// File: tb/sim_idcrc8_serial.sv
`timescale 1ns/1ps
module sim_idcrc8_serial;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [7:0] rem_o;
  logic       code_ok_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model: bits since clear kept in a queue
  bit   mq[$];

  always #4 clk = ~clk;

  idcrc8_serial u0 (.*);

  function automatic logic [7:0] ref_rem();
    logic [7:0] r = 8'h00;
    foreach (mq[i]) begin
      if ((mq[i] ^ r[0]) == 1'b1) r = (r >> 1) ^ 8'h8C;
      else                        r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] crc56(input logic [63:0] code);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 56; i++) begin
      if ((code[i] ^ r[0]) == 1'b1) r = (r >> 1) ^ 8'h8C;
      else                          r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare after the next posedge
  task automatic cyc(input logic c, input logic v, input logic b);
    clr_i = c; bit_vld_i = v; bit_i = b;
    if (c) mq.delete();
    else if (v) mq.push_back(b);
    @(posedge clk);
    @(negedge clk);
    check("R3/R4 remainder", rem_o, ref_rem());
    check("R7 flag", {7'd0, code_ok_o},
          {7'd0, (mq.size() == 64 && ref_rem() == 8'h00)});
  endtask

  task automatic stream(input logic [63:0] code, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, code[i]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset remainder", rem_o, 8'h00);
    check("R1 reset flag", {7'd0, code_ok_o}, 8'h00);

    // R5 known vector
    code = 64'hA200_0000_01B8_1C02;
    cyc(1'b1, 1'b0, 1'b0);
    stream(code, 56);
    check("R5 check byte", rem_o, 8'hA2);
    repeat (3) cyc(1'b0, 1'b0, 1'b0); // R4 idle
    check("R4 hold", rem_o, 8'hA2);
    stream(code >> 56, 8);
    check("R6 residue", rem_o, 8'h00);
    check("R6 flag", {7'd0, code_ok_o}, 8'h01);
    cyc(1'b0, 1'b1, 1'b0);
    check("R7 65th bit flag", {7'd0, code_ok_o}, 8'h00);

    // R2 clear beats strobe
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    check("R2 clear priority", rem_o, 8'h00);

    // R7 all-zero code lengths
    stream(64'd0, 63);
    check("R7 63 bits", {7'd0, code_ok_o}, 8'h00);
    stream(64'd0, 1);
    check("R7 64 bits", {7'd0, code_ok_o}, 8'h01);
    stream(64'd0, 2);
    check("R7 66 bits", {7'd0, code_ok_o}, 8'h00);

    // family 0x27 codes, R6 and R8
    for (int k = 0; k < 4; k++) begin
      code[7:0]   = 8'h27;
      code[55:8]  = 48'h1234_5678_9ABC * (k + 3) + k;
      code[63:56] = crc56(code);
      cyc(1'b1, 1'b0, 1'b0);
      stream(code, 56);
      check("R5 computed byte", rem_o, code[63:56]);
      stream(code >> 56, 8);
      check("R6 valid", {7'd0, code_ok_o}, 8'h01);
      cyc(1'b1, 1'b0, 1'b0);
      stream(code ^ (64'd1 << (k * 17 + 5)), 64);
      check("R8 corrupt", {7'd0, code_ok_o}, 8'h00);
    end

    // R2 mid-stream clear restarts
    stream(64'hFFFF, 20);
    cyc(1'b1, 1'b0, 1'b0);
    code = 64'hA200_0000_01B8_1C02;
    stream(code, 64);
    check("R2 restart valid", {7'd0, code_ok_o}, 8'h01);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule